// File: doc/BRIEF.md
# Serial multi-precision narrow adder

This block adds or subtracts two wide operands with one narrow adder slice that is used again on each clock cycle. A start strobe captures both operands, the operation select and the number-class select. The block then works from the least significant slice upward, one slice per cycle. A carry register passes each slice's carry-out to the next slice's carry-in. The result is built by shifting each new slice in at the top of a result register.

After the last slice, a one-cycle done strobe marks the result and the whole-word flags as valid. The flags are the final carry (or borrow, when subtracting), an overflow flag and a zero flag. The overflow flag follows the unsigned or two's complement rule, depending on the number-class select. The operand width `OP_W` must be a whole multiple of the slice width `SL_W`, which gives `NSL = OP_W / SL_W` slices.

The controller has three named states. `ST_IDLE` waits for start, and the transition on start is called *load*. `ST_RUN` handles one slice per cycle: it stays in `ST_RUN` while more slices remain (*step*) and moves to `ST_DONE` on the last slice (*last*). `ST_DONE` raises done for one cycle and always returns to `ST_IDLE` (*retire*).

Top module: `serial_wide_adder`

## Requirements
- R1: When start is high in `ST_IDLE`, op_a, op_b, sub_i and signed_i are captured. At done, sum_o equals (A+B) mod 2^OP_W when sub_i=0 and (A−B) mod 2^OP_W when sub_i=1.
- R2: Slices are processed least significant first. The first carry-in is 0 for add and 1 for subtract, and a subtract uses the inverted slices of B. Every later slice takes the registered carry-out of the slice before it.
- R3: done_o is high for exactly one cycle, NSL clock edges after the edge that sampled start, and is low at every other time. sum_o and the flags hold their values in the cycle after done.
- R4: carry_o is the final carry-out for an add. For a subtract it is the borrow, which is 1 exactly when A < B taken as unsigned numbers.
- R5: With signed_i=0, ovf_o equals carry_o, meaning the unsigned result does not fit in OP_W bits.
- R6: With signed_i=1, ovf_o is 1 exactly when the true signed sum or difference lies outside the OP_W-bit two's complement range, i.e. the carry into the top bit differs from the carry out of it. For example, −2 + −2 does not overflow.
- R7: zero_o is 1 exactly when all OP_W bits of sum_o are 0. It is built as the AND of per-slice zero tests taken across the iterations.
- R8: A start pulse, together with changed operands and selects, while the block is in `ST_RUN` or `ST_DONE`, has no effect. The running result is unchanged and no extra done appears.
- R9: After reset, done_o, sum_o, carry_o, ovf_o and zero_o are all 0 and the block is in `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only in ST_IDLE) |
| sub_i | input | 1 | 1 = subtract B from A, 0 = add |
| signed_i | input | 1 | 1 = two's complement overflow rule, 0 = unsigned |
| op_a | input | OP_W | First operand |
| op_b | input | OP_W | Second operand |
| sum_o | output | OP_W | Assembled result |
| done_o | output | 1 | One-cycle strobe: result and flags valid |
| carry_o | output | 1 | Final carry (add) or borrow (subtract) |
| ovf_o | output | 1 | Overflow under the selected number rule |
| zero_o | output | 1 | Result is all zeros |

## Verification
Every result comes due NSL edges after the edge that sampled start. The bench drives start just after a falling edge, then samples on each of the following falling edges. It checks that done is low on the first NSL of those samples and high on sample NSL+1. The same sample is used to compare the result and all three flags with values computed arithmetically from the operands. One further sample checks that done has dropped and that the result has held. The sweep covers every operand pair of a 6-bit, three-slice configuration in all four combinations of add/subtract and signed/unsigned. Some runs also raise start with different operands while the block is busy.

// File: rtl/swa_pkg.sv
package swa_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } swa_state_e;
endpackage

// File: rtl/swa_slice_add.sv
module swa_slice_add #(
    parameter int SL_W = 8
) (
    input  logic [SL_W-1:0] a,
    input  logic [SL_W-1:0] b,
    input  logic            cin,
    output logic [SL_W-1:0] sum,
    output logic            cout,
    output logic            c_top_in
);
    generate
        if (SL_W == 1) begin : g_single_bit
            assign c_top_in = cin;
            assign sum      = a ^ b ^ cin;
            assign cout     = (a[0] & b[0]) | (a[0] & cin) | (b[0] & cin);
        end else begin : g_multi_bit
            // lower SL_W-1 bits plus their carry into the top bit
            logic [SL_W-1:0] low;
            logic            top_sum;
            assign low      = {1'b0, a[SL_W-2:0]} + {1'b0, b[SL_W-2:0]}
                            + {{(SL_W-1){1'b0}}, cin};
            assign c_top_in = low[SL_W-1];
            assign top_sum  = a[SL_W-1] ^ b[SL_W-1] ^ c_top_in;
            assign cout     = (a[SL_W-1] & b[SL_W-1]) | (a[SL_W-1] & c_top_in)
                            | (b[SL_W-1] & c_top_in);
            assign sum      = {top_sum, low[SL_W-2:0]};
        end
    endgenerate
endmodule

// File: rtl/swa_ctrl.sv
module swa_ctrl
    import swa_pkg::*;
#(
    parameter int NSL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic last,
    output logic done_o
);
    localparam int CW = (NSL > 1) ? $clog2(NSL) : 1;

    swa_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = ST_RUN;                 // load
            ST_RUN:  if (cnt_q == CW'(NSL-1)) st_d = ST_DONE;  // last, else step
            ST_DONE: st_d = ST_IDLE;                           // retire
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and slice counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start)
                cnt_q <= '0;
            else if (st_q == ST_RUN)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        load   = (st_q == ST_IDLE) && start;
        step   = (st_q == ST_RUN);
        last   = (st_q == ST_RUN) && (cnt_q == CW'(NSL-1));
        done_o = (st_q == ST_DONE);
    end

    // R3: done lasts a single cycle
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3: the last slice is followed by done
    a_r3_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> done_o);
    // R8: a running operation advances one slice per cycle, start or not
    a_r8_run_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !last) |=> (st_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/serial_wide_adder.sv
module serial_wide_adder #(
    parameter int OP_W = 32,
    parameter int SL_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            sub_i,
    input  logic            signed_i,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic [OP_W-1:0] sum_o,
    output logic            done_o,
    output logic            carry_o,
    output logic            ovf_o,
    output logic            zero_o
);
    localparam int NSL = OP_W / SL_W;

    initial begin
        if (NSL * SL_W != OP_W || SL_W < 1)
            $error("OP_W must be a whole multiple of SL_W");
    end

    logic            load, step, last;
    logic [OP_W-1:0] a_q, b_q, res_q, res_d;
    logic            cy_q, zacc_q, sub_q, sgn_q;
    logic            carry_q, ovf_q, zero_q;
    logic [SL_W-1:0] s_b, s_sum;
    logic            s_cout, s_ctop, s_zero;

    swa_ctrl #(.NSL(NSL)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .load   (load),
        .step   (step),
        .last   (last),
        .done_o (done_o)
    );

    assign s_b = sub_q ? ~b_q[SL_W-1:0] : b_q[SL_W-1:0];

    swa_slice_add #(.SL_W(SL_W)) u_slice (
        .a        (a_q[SL_W-1:0]),
        .b        (s_b),
        .cin      (cy_q),
        .sum      (s_sum),
        .cout     (s_cout),
        .c_top_in (s_ctop)
    );

    assign s_zero = (s_sum == '0);

    generate
        if (NSL == 1) begin : g_one_slice
            assign res_d = s_sum;
        end else begin : g_many_slices
            assign res_d = {s_sum, res_q[OP_W-1:SL_W]};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q     <= '0;
            b_q     <= '0;
            res_q   <= '0;
            cy_q    <= 1'b0;
            zacc_q  <= 1'b0;
            sub_q   <= 1'b0;
            sgn_q   <= 1'b0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
            zero_q  <= 1'b0;
        end else if (load) begin
            a_q    <= op_a;
            b_q    <= op_b;
            cy_q   <= sub_i;
            zacc_q <= 1'b1;
            sub_q  <= sub_i;
            sgn_q  <= signed_i;
        end else if (step) begin
            a_q    <= a_q >> SL_W;
            b_q    <= b_q >> SL_W;
            res_q  <= res_d;
            cy_q   <= s_cout;
            zacc_q <= zacc_q & s_zero;
            if (last) begin
                carry_q <= sub_q ? ~s_cout : s_cout;
                ovf_q   <= sgn_q ? (s_ctop ^ s_cout) : (sub_q ? ~s_cout : s_cout);
                zero_q  <= zacc_q & s_zero;
            end
        end
    end

    assign sum_o   = res_q;
    assign carry_o = carry_q;
    assign ovf_o   = ovf_q;
    assign zero_o  = zero_q;

    // R2: first carry-in follows the operation select
    a_r2_first_cin: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cy_q == sub_q));
    // R5: unsigned overflow agrees with carry/borrow
    a_r5_unsigned_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !sgn_q) |-> (ovf_o == carry_o));
    // R7: zero flag agrees with the assembled result
    a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (zero_o == (sum_o == '0)));
    // R3: result holds in the cycle after done
    a_r3_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> $stable(sum_o));
endmodule

// File: tb/serial_wide_adder_test.sv
module serial_wide_adder_test;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 6;
    localparam int S   = 2;
    localparam int NSL = W / S;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sub_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] sum_o;
    logic         done_o, carry_o, ovf_o, zero_o;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_wide_adder #(.OP_W(W), .SL_W(S)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .sub_i    (sub_i),
        .signed_i (signed_i),
        .op_a     (op_a),
        .op_b     (op_b),
        .sum_o    (sum_o),
        .done_o   (done_o),
        .carry_o  (carry_o),
        .ovf_o    (ovf_o),
        .zero_o   (zero_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sval(input int v);
        return (v >= (1 << (W-1))) ? v - (1 << W) : v;
    endfunction

    // one operation; disturb raises start with other operands while busy (R8)
    task automatic run_op(input int a, input int b, input bit sub, input bit sgn,
                          input bit disturb);
        int full, e_res, e_cy, e_ovf, e_zero, sres, held;
        if (sub) full = a + ((~b) & MASK) + 1;
        else     full = a + b;
        e_res  = full & MASK;
        e_cy   = sub ? ((a < b) ? 1 : 0) : (full >> W);
        sres   = sub ? sval(a) - sval(b) : sval(a) + sval(b);
        e_ovf  = sgn ? ((sres > (1 << (W-1)) - 1 || sres < -(1 << (W-1))) ? 1 : 0) : e_cy;
        e_zero = (e_res == 0) ? 1 : 0;

        @(negedge clk);
        op_a = W'(a); op_b = W'(b); sub_i = sub; signed_i = sgn; start = 1'b1;
        @(negedge clk);
        if (disturb) begin
            op_a = W'(~a); op_b = W'(a ^ 21); sub_i = ~sub; signed_i = ~sgn;
        end else begin
            start = 1'b0;
        end
        for (int k = 1; k <= NSL; k++) begin
            chk(done_o == 1'b0, "R3 done early", int'(done_o), 0);
            @(negedge clk);
        end
        start = 1'b0;
        chk(done_o == 1'b1, "R3 done timing", int'(done_o), 1);
        chk(int'(sum_o) == e_res, disturb ? "R8 result" : "R1 R2 result", int'(sum_o), e_res);
        chk(int'(carry_o) == e_cy, "R4 carry/borrow", int'(carry_o), e_cy);
        chk(int'(ovf_o) == e_ovf, sgn ? "R6 signed ovf" : "R5 unsigned ovf", int'(ovf_o), e_ovf);
        chk(int'(zero_o) == e_zero, "R7 zero", int'(zero_o), e_zero);
        held = int'(sum_o);
        @(negedge clk);
        chk(done_o == 1'b0, disturb ? "R8 extra done" : "R3 done width", int'(done_o), 0);
        chk(int'(sum_o) == held, "R3 hold", int'(sum_o), held);
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(done_o == 1'b0, "R9 done", int'(done_o), 0);
        chk(sum_o == '0, "R9 sum", int'(sum_o), 0);
        chk({carry_o, ovf_o, zero_o} == 3'b000, "R9 flags", int'({carry_o, ovf_o, zero_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0, "R9 idle", int'(done_o), 0);

        // named corner cases
        run_op(62, 62, 1'b0, 1'b1, 1'b0);  // R6: -2 + -2, no overflow
        run_op(32, 60, 1'b0, 1'b1, 1'b0);  // R6: -32 + -4 overflows
        run_op(31,  1, 1'b0, 1'b1, 1'b0);  // R6: 31 + 1 overflows
        run_op(13, 13, 1'b1, 1'b0, 1'b0);  // R7: zero from subtract
        run_op( 3,  9, 1'b1, 1'b0, 1'b0);  // R4: borrow
        run_op(63,  1, 1'b0, 1'b0, 1'b0);  // R2: carry ripples through every slice
        run_op(22, 45, 1'b0, 1'b0, 1'b1);  // R8: start while busy
        run_op(40,  7, 1'b1, 1'b1, 1'b1);  // R8: start while busy, subtract

        // exhaustive sweep over operands, add/sub and signed/unsigned
        for (int m = 0; m < 4; m++)
            for (int a = 0; a <= MASK; a++)
                for (int b = 0; b <= MASK; b++)
                    run_op(a, b, m[0], m[1], 1'b0);

        finish_up();
    end
endmodule